// File: doc/BRIEF.md
# Rank Low-Power Mode Manager

This block runs the low-power policy for one DRAM rank inside a memory controller. It watches every command the controller issues to the rank, keeps a count of the banks that are open, and follows the rank through five modes: idle, active power-down, precharge power-down, self-refresh, and a post-self-refresh recovery mode that lasts until one all-bank refresh has been issued. From that history and a controller-idle level it decides which mode change the command scheduler should perform next. It presents that choice as a registered request.

The controller owns the command bus. The manager only asks for a command. A request stays asserted until the controller issues the requested command through the command strobe. A refresh that lands while the controller is idle arms entry into power-down. After an exit from precharge power-down during idle time, the next armed entry escalates to self-refresh. Leaving self-refresh places the rank in the recovery mode, and only an all-bank refresh returns it to idle.

Top module: `rank_pd_manager`

## Requirements
- R1: After a synchronous active-high reset, `req_valid` is 0 and `pwr_state` is 0 (idle). The open-bank count is 0 and the entry, exit and self-refresh-pending flags are clear.
- R2: The open-bank count rises by one on ACT (code 6) and saturates at NUM_BANKS. It falls by one on PRE (code 5) and stops at 0. PREA (code 8) clears it. An armed entry requests PDEA (code 10) when the count is non-zero and PDEP (code 12) when it is zero.
- R3: In any mode except recovery (4), a REFA (code 9) issued while `ctrl_idle` is 1 arms entry. A REFB (code 7) issued while `ctrl_idle` is 1 also arms entry. A refresh issued while `ctrl_idle` is 0 arms nothing. An entry request is made only in idle (0) while `ctrl_idle` is 1.
- R4: PDEA sets `pwr_state` to 1 (active power-down). PDEP sets it to 2 (precharge power-down). SREFEN (code 14) sets it to 3 (self-refresh). Each of these three commands disarms entry.
- R5: In mode 1 or 2, `ctrl_idle` at 0 latches an exit. The exit request (PDXA, code 11, from mode 1; PDXP, code 13, from mode 2) then holds even if `ctrl_idle` returns to 1. PDXA or PDXP returns `pwr_state` to 0 and clears the exit latch.
- R6: A PDXP issued while `ctrl_idle` is 1 marks self-refresh pending. The next armed entry then requests SREFEN instead of a power-down. SREFEN clears the pending mark.
- R7: In mode 3, `ctrl_idle` at 0 requests SREFEX (code 15). SREFEX sets `pwr_state` to 4. The next REFA in mode 4 returns the state to 0 and does not arm entry.
- R8: `req_valid` and `req_cmd` are registered. They reflect a command or a `ctrl_idle` change one rising clock edge after it is presented. All other codes (0 to 4) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command was issued to the rank this cycle |
| cmd_code | input | 4 | Code of the issued command |
| ctrl_idle | input | 1 | Controller has no pending work for this rank |
| req_valid | output | 1 | A mode-change command is requested |
| req_cmd | output | 4 | Code of the requested command |
| pwr_state | output | 3 | Current mode: 0 idle, 1 active pd, 2 precharge pd, 3 self-refresh, 4 recovery |

## Verification
The hardest situation to reach is the escalation path. It needs a precharge power-down entered with the count at zero, an exit latched while busy, and a PDXP issued after the controller has gone idle again. Only then does an idle refresh yield SREFEN, and then SREFEX and a recovery REFA must follow. The bench drives that sequence explicitly, then checks that the following entry falls back to an ordinary power-down. A sweep over ACT and PRE counts, including saturation at both ends, exercises the choice between the two power-down kinds across the whole counter range.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic [3:0] {
    CMD_NOP    = 4'd0,
    CMD_RD     = 4'd1,
    CMD_WR     = 4'd2,
    CMD_RDA    = 4'd3,
    CMD_WRA    = 4'd4,
    CMD_PRE    = 4'd5,
    CMD_ACT    = 4'd6,
    CMD_REFB   = 4'd7,
    CMD_PREA   = 4'd8,
    CMD_REFA   = 4'd9,
    CMD_PDEA   = 4'd10,
    CMD_PDXA   = 4'd11,
    CMD_PDEP   = 4'd12,
    CMD_PDXP   = 4'd13,
    CMD_SREFEN = 4'd14,
    CMD_SREFEX = 4'd15
  } lp_cmd_e;

  typedef enum logic [2:0] {
    M_IDLE    = 3'd0,
    M_ACT_PDN = 3'd1,
    M_PRE_PDN = 3'd2,
    M_SREF    = 3'd3,
    M_RECOVER = 3'd4
  } lp_mode_e;
endpackage

// File: rtl/lp_bank_count.sv
module lp_bank_count
  import lp_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int CW = $clog2(NUM_BANKS + 1)
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cmd_valid,
  input  lp_cmd_e cmd,
  output logic    any_open_nxt
);
  localparam logic [CW-1:0] MAXC = CW'(NUM_BANKS);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cmd_valid) begin
      case (cmd)
        CMD_ACT:  if (cnt_q != MAXC) cnt_d = cnt_q + 1'b1;
        CMD_PRE:  if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        CMD_PREA: cnt_d = '0;
        default:  cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign any_open_nxt = (cnt_d != '0);
endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cmd_valid,
  input  lp_cmd_e  cmd,
  input  logic     ctrl_idle,
  output lp_mode_e mode_nxt,
  output lp_mode_e mode_q,
  output logic     entry_nxt,
  output logic     exit_nxt,
  output logic     sref_nxt
);
  logic entry_q, exit_q, sref_q;

  always_comb begin
    mode_nxt  = mode_q;
    entry_nxt = entry_q;
    sref_nxt  = sref_q;
    exit_nxt  = exit_q;
    if (cmd_valid) begin
      case (cmd)
        CMD_PDEA: begin mode_nxt = M_ACT_PDN; entry_nxt = 1'b0; end
        CMD_PDEP: begin mode_nxt = M_PRE_PDN; entry_nxt = 1'b0; end
        CMD_SREFEN: begin
          mode_nxt  = M_SREF;
          entry_nxt = 1'b0;
          sref_nxt  = 1'b0;
        end
        CMD_PDXA: begin mode_nxt = M_IDLE; exit_nxt = 1'b0; end
        CMD_PDXP: begin
          mode_nxt = M_IDLE;
          exit_nxt = 1'b0;
          if (ctrl_idle) sref_nxt = 1'b1;
        end
        CMD_SREFEX: mode_nxt = M_RECOVER;
        CMD_REFA: begin
          if (mode_q == M_RECOVER) mode_nxt = M_IDLE;
          else if (ctrl_idle)      entry_nxt = 1'b1;
        end
        CMD_REFB: if (ctrl_idle) entry_nxt = 1'b1;
        default: ;
      endcase
    end
    if ((mode_nxt == M_ACT_PDN || mode_nxt == M_PRE_PDN) && !ctrl_idle)
      exit_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_IDLE;
      entry_q <= 1'b0;
      exit_q  <= 1'b0;
      sref_q  <= 1'b0;
    end else begin
      mode_q  <= mode_nxt;
      entry_q <= entry_nxt;
      exit_q  <= exit_nxt;
      sref_q  <= sref_nxt;
    end
  end
endmodule

// File: rtl/lp_req_sel.sv
module lp_req_sel
  import lp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  lp_mode_e mode_nxt,
  input  logic     entry_nxt,
  input  logic     exit_nxt,
  input  logic     sref_nxt,
  input  logic     any_open_nxt,
  input  logic     ctrl_idle,
  output logic     req_valid,
  output lp_cmd_e  req_cmd
);
  logic    v_d;
  lp_cmd_e c_d;

  always_comb begin
    v_d = 1'b0;
    c_d = CMD_NOP;
    case (mode_nxt)
      M_IDLE: if (entry_nxt && ctrl_idle) begin
        v_d = 1'b1;
        if (sref_nxt)          c_d = CMD_SREFEN;
        else if (any_open_nxt) c_d = CMD_PDEA;
        else                   c_d = CMD_PDEP;
      end
      M_ACT_PDN: if (exit_nxt) begin v_d = 1'b1; c_d = CMD_PDXA; end
      M_PRE_PDN: if (exit_nxt) begin v_d = 1'b1; c_d = CMD_PDXP; end
      M_SREF:    if (!ctrl_idle) begin v_d = 1'b1; c_d = CMD_SREFEX; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_cmd   <= CMD_NOP;
    end else begin
      req_valid <= v_d;
      req_cmd   <= c_d;
    end
  end
endmodule

// File: rtl/rank_pd_manager.sv
module rank_pd_manager
  import lp_pkg::*;
#(
  parameter int NUM_BANKS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  input  logic       ctrl_idle,
  output logic       req_valid,
  output logic [3:0] req_cmd,
  output logic [2:0] pwr_state
);
  lp_cmd_e  cmd;
  lp_cmd_e  req_e;
  lp_mode_e mode_nxt, mode_q;
  logic     entry_nxt, exit_nxt, sref_nxt, any_open_nxt;

  assign cmd = lp_cmd_e'(cmd_code);

  lp_bank_count #(.NUM_BANKS(NUM_BANKS)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd          (cmd),
    .any_open_nxt (any_open_nxt)
  );

  lp_mode_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .ctrl_idle (ctrl_idle),
    .mode_nxt  (mode_nxt),
    .mode_q    (mode_q),
    .entry_nxt (entry_nxt),
    .exit_nxt  (exit_nxt),
    .sref_nxt  (sref_nxt)
  );

  lp_req_sel u_req (
    .clk          (clk),
    .rst          (rst),
    .mode_nxt     (mode_nxt),
    .entry_nxt    (entry_nxt),
    .exit_nxt     (exit_nxt),
    .sref_nxt     (sref_nxt),
    .any_open_nxt (any_open_nxt),
    .ctrl_idle    (ctrl_idle),
    .req_valid    (req_valid),
    .req_cmd      (req_e)
  );

  assign req_cmd   = 4'(req_e);
  assign pwr_state = 3'(mode_q);
endmodule

// File: rtl/rank_pd_manager_chk.sv
module rank_pd_manager_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [3:0] cmd_code,
  input logic       ctrl_idle,
  input logic       req_valid,
  input logic [3:0] req_cmd,
  input logic [2:0] pwr_state
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!req_valid && pwr_state == 3'd0)); // R1

  AST_ENTRY_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_cmd == 4'd10 || req_cmd == 4'd12 || req_cmd == 4'd14))
      |-> pwr_state == 3'd0); // R3

  AST_PDE_STATE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 4'd10) |=> pwr_state == 3'd1); // R4

  AST_SREFEN_STATE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 4'd14) |=> pwr_state == 3'd3); // R4

  AST_PDXA_ONLY_ACTPD: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cmd == 4'd11) |-> pwr_state == 3'd1); // R5

  AST_PDX_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_code == 4'd11 || cmd_code == 4'd13)) |=> pwr_state == 3'd0); // R5

  AST_SREFEX_ONLY_SREF: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cmd == 4'd15) |-> pwr_state == 3'd3); // R7

  AST_RECOVER_REFA: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 4'd9 && pwr_state == 3'd4) |=> pwr_state == 3'd0); // R7

  AST_STATE_RANGE: assert property (@(posedge clk) disable iff (rst)
    pwr_state <= 3'd4); // R4
endmodule

bind rank_pd_manager rank_pd_manager_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_code  (cmd_code),
  .ctrl_idle (ctrl_idle),
  .req_valid (req_valid),
  .req_cmd   (req_cmd),
  .pwr_state (pwr_state)
);

// File: tb/test_rank_pd_manager.sv
`timescale 1ns/1ps
module test_rank_pd_manager;
  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic       ctrl_idle = 1'b1;
  logic       req_valid;
  logic [3:0] req_cmd;
  logic [2:0] pwr_state;

  int n_chk = 0;
  int n_bad = 0;
  bit timed_out = 1'b0;

  always #10 clk = ~clk;

  rank_pd_manager #(.NUM_BANKS(NB)) i_rank_pd_manager (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .ctrl_idle(ctrl_idle), .req_valid(req_valid), .req_cmd(req_cmd),
    .pwr_state(pwr_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 4'd0;
  endtask

  task automatic set_idle(input logic v);
    @(negedge clk);
    ctrl_idle = v;
    @(negedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req_valid", int'(req_valid), 0);
    chk("R1 pwr_state", int'(pwr_state), 0);

    // R8: request appears only after the edge; R3 REFB while idle arms entry
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 4'd7;
    #5;
    chk("R8 before edge", int'(req_valid), 0);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = 4'd0;
    chk("R8 after edge", int'(req_valid), 1);
    chk("R1 count zero -> PDEP", int'(req_cmd), 12);
    issue(4'd12);
    chk("R4 PDEP state", int'(pwr_state), 2);
    set_idle(1'b0);
    issue(4'd13);
    set_idle(1'b1);

    // R8 ignored codes: RD/WR/RDA/WRA/NOP change nothing
    for (int k = 0; k < 5; k++) issue(4'(k));
    chk("R8 ignored codes req", int'(req_valid), 0);
    chk("R8 ignored codes state", int'(pwr_state), 0);

    // R3: refresh while busy arms nothing
    set_idle(1'b0);
    issue(4'd7);
    issue(4'd9);
    chk("R3 busy refresh req", int'(req_valid), 0);
    set_idle(1'b1);
    chk("R3 busy refresh not armed", int'(req_valid), 0);

    // R2..R5 sweep over ACT/PRE counts
    for (int a = 0; a <= NB + 1; a++) begin
      for (int p = 0; p <= NB + 1; p++) begin
        int sat;
        int expc;
        int ent;
        int ext;
        issue(4'd8);
        for (int i = 0; i < a; i++) issue(4'd6);
        for (int i = 0; i < p; i++) issue(4'd5);
        chk("R3 no trigger yet", int'(req_valid), 0);
        sat  = (a > NB) ? NB : a;
        expc = (sat > p) ? sat - p : 0;
        ent  = (expc != 0) ? 10 : 12;
        ext  = (expc != 0) ? 11 : 13;
        issue(((a + p) % 2 == 0) ? 4'd7 : 4'd9);
        chk("R3 armed req", int'(req_valid), 1);
        chk("R2 entry kind", int'(req_cmd), ent);
        issue(4'(ent));
        chk("R4 pd state", int'(pwr_state), (expc != 0) ? 1 : 2);
        chk("R4 entry disarmed", int'(req_valid), 0);
        set_idle(1'b0);
        chk("R5 exit req", int'(req_cmd), ext);
        set_idle(1'b1);
        chk("R5 exit latched", int'(req_valid), 1);
        set_idle(1'b0);
        issue(4'(ext));
        chk("R5 back idle", int'(pwr_state), 0);
        chk("R5 no req after exit", int'(req_valid), 0);
        set_idle(1'b1);
      end
    end

    // R6/R7 escalation path
    issue(4'd8);
    issue(4'd7);
    chk("R2 cleared -> PDEP", int'(req_cmd), 12);
    issue(4'd12);
    set_idle(1'b0);
    set_idle(1'b1);
    issue(4'd13);
    chk("R6 after idle PDXP req", int'(req_valid), 0);
    issue(4'd9);
    chk("R6 escalate req", int'(req_valid), 1);
    chk("R6 escalate kind", int'(req_cmd), 14);
    issue(4'd14);
    chk("R4 SREFEN state", int'(pwr_state), 3);
    chk("R7 no req while idle in sref", int'(req_valid), 0);
    set_idle(1'b0);
    chk("R7 SREFEX req", int'(req_cmd), 15);
    issue(4'd15);
    chk("R7 recovery state", int'(pwr_state), 4);
    chk("R7 no req in recovery", int'(req_valid), 0);
    set_idle(1'b1);
    issue(4'd9);
    chk("R7 REFA exits recovery", int'(pwr_state), 0);
    chk("R7 REFA does not arm", int'(req_valid), 0);
    issue(4'd7);
    chk("R6 pending cleared -> PDEP", int'(req_cmd), 12);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule